// File: doc/BRIEF.md
# Sync-Locked Channel Sample Extractor

This block sits on a continuous stream of 16-bit words, one word for each cycle in which `word_vld` is high. The stream is made of repeating frames. Each frame has a three-word header and then one 16-bit sample for each of `NUM_CH` channels (320 by default). The header holds a three-byte sync pattern, 0x0A, 0x0B and 0x0C, followed by a 24-bit epoch count. The epoch count is sent most significant byte first, so the sync pattern runs across a word boundary.

The block hunts for the sync pattern and locks onto the frame. After that it counts words from the header. A static channel number on `chan_sel`, set the way a switch would be, picks one slot. The word in that slot is registered in every frame and marked with a one-cycle strobe. The epoch count from the header is presented once per frame. While locked, the block checks the header at every frame boundary and drops lock on any mismatch. It then goes back to hunting.

Top module: `chan_sample_extractor`

## Requirements
- R1: While reset is asserted and on release, `locked`, `sample_stb`, `sample_q` and `epoch_cnt` are all zero.
- R2: Bytes are ordered with bits [15:8] first. Lock is acquired only when a valid word equal to 0x0A0B is followed by a valid word whose bits [15:8] equal 0x0C. `locked` rises in the cycle after that second word, and stays low for any stream that lacks this pair.
- R3: If a valid word after a 0x0A0B candidate is not a sync continuation, lock is not acquired. If that word is itself 0x0A0B, it becomes the new candidate.
- R4: The frame word at offset 0 is the 0x0A0B header word. For `chan_sel` = s with 1 <= s <= `NUM_CH`, the valid word at offset s+2 of each locked frame is stored in `sample_q`. `sample_stb` is high for exactly the cycle after that word.
- R5: A `chan_sel` value of 0 or above `NUM_CH` never produces a strobe.
- R6: The header word at offset 1 carries the epoch high byte in bits [7:0]. The word at offset 2 carries the middle and low bytes. `epoch_cnt` takes the assembled 24-bit value in the cycle after the offset-2 word, and this includes the frame in which lock was acquired.
- R7: While locked, the word at offset 0 of the next frame, 3+`NUM_CH` words later, must equal 0x0A0B, and the word at offset 1 must carry 0x0C in bits [15:8]. Any mismatch clears `locked` in the next cycle and restarts the hunt.
- R8: Cycles with `word_vld` low are ignored whatever `word_in` holds. Frame position, lock, strobe and epoch do not move.
- R9: `sample_q` holds its value between strobes, and this includes after lock is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_vld | input | 1 | Qualifies `word_in` for this cycle |
| word_in | input | 16 | Stream word, first byte in [15:8] |
| chan_sel | input | 9 | Channel number to capture, 1 to NUM_CH |
| sample_q | output | 16 | Last captured sample of the selected channel |
| sample_stb | output | 1 | One-cycle pulse when `sample_q` is reloaded |
| locked | output | 1 | Frame lock flag |
| epoch_cnt | output | 24 | Epoch count from the latest locked header |

## Verification
The bench sweeps every channel number from 1 to 320 across consecutive locked frames and checks the strobe on every word. An off-by-one in the slot offset would therefore strobe one word early or late and capture a neighbour's sample. Selector values 0, 321 and 511 are driven to catch a range check that lets edge values through and strobes a header word. Near-miss sync sequences (0x0A0B followed by a wrong byte, and repeated 0x0A0B) target a detector that locks on half a pattern or loses the second candidate. Corrupting the first and second header words targets a tracker that never drops lock or drops it a cycle late. Idle cycles that carry sync-like data, and sample retention across lock loss, target a design that counts unqualified words or clears the held sample.

// File: rtl/cse_pkg.sv
package cse_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int HDR_WORDS = 3;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_CAND = 2'd1,
        ST_LOCK = 2'd2
    } lock_st_e;
endpackage

// File: rtl/cse_sync_cmp.sv
module cse_sync_cmp
    import cse_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SYNC_A = 8'h0A,
    parameter logic [BYTE_W-1:0] SYNC_B = 8'h0B,
    parameter logic [BYTE_W-1:0] SYNC_C = 8'h0C
) (
    input  logic [WORD_W-1:0] word_in,
    output logic              lead_hit,
    output logic              tail_hit
);
    always_comb begin
        lead_hit = (word_in == {SYNC_A, SYNC_B});
        tail_hit = (word_in[WORD_W-1:BYTE_W] == SYNC_C);
    end
endmodule

// File: rtl/cse_frame_trk.sv
module cse_frame_trk
    import cse_pkg::*;
#(
    parameter int NUM_CH = 320,
    localparam int FRAME_LEN = NUM_CH + HDR_WORDS,
    localparam int IDX_W = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_vld,
    input  logic             lead_hit,
    input  logic             tail_hit,
    output logic             locked,
    output logic             in_frame,
    output logic [IDX_W-1:0] word_idx,
    output logic             hi_take,
    output logic             lo_take
);
    typedef struct packed {
        lock_st_e         st;
        logic [IDX_W-1:0] pos;
    } trk_s;

    trk_s trk_d, trk_q;

    always_comb begin
        trk_d    = trk_q;
        hi_take  = 1'b0;
        lo_take  = 1'b0;
        word_idx = (trk_q.pos == IDX_W'(FRAME_LEN - 1)) ? '0 : trk_q.pos + 1'b1;
        in_frame = word_vld && (trk_q.st == ST_LOCK);
        if (word_vld) begin
            case (trk_q.st)
                ST_HUNT: begin
                    if (lead_hit) trk_d.st = ST_CAND;
                end
                ST_CAND: begin
                    if (tail_hit) begin
                        trk_d.st  = ST_LOCK;
                        trk_d.pos = IDX_W'(1);
                        hi_take   = 1'b1;
                    end else if (!lead_hit) begin
                        trk_d.st = ST_HUNT;
                    end
                end
                ST_LOCK: begin
                    trk_d.pos = word_idx;
                    if (word_idx == '0) begin
                        if (!lead_hit) trk_d.st = ST_HUNT;
                    end else if (word_idx == IDX_W'(1)) begin
                        if (tail_hit) hi_take = 1'b1;
                        else trk_d.st = lead_hit ? ST_CAND : ST_HUNT;
                    end else if (word_idx == IDX_W'(2)) begin
                        lo_take = 1'b1;
                    end
                end
                default: trk_d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q.st  <= ST_HUNT;
            trk_q.pos <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign locked = (trk_q.st == ST_LOCK);
endmodule

// File: rtl/cse_capture.sv
module cse_capture
    import cse_pkg::*;
#(
    parameter int NUM_CH = 320,
    localparam int FRAME_LEN = NUM_CH + HDR_WORDS,
    localparam int IDX_W = $clog2(FRAME_LEN),
    localparam int SEL_W = $clog2(NUM_CH + 1),
    localparam int CMP_W = ((IDX_W > SEL_W) ? IDX_W : SEL_W) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  word_in,
    input  logic [SEL_W-1:0]   chan_sel,
    input  logic               in_frame,
    input  logic [IDX_W-1:0]   word_idx,
    input  logic               hi_take,
    input  logic               lo_take,
    output logic [WORD_W-1:0]  sample_q,
    output logic               sample_stb,
    output logic [3*BYTE_W-1:0] epoch_cnt
);
    typedef struct packed {
        logic [WORD_W-1:0]   sample;
        logic                stb;
        logic [BYTE_W-1:0]   hi;
        logic [3*BYTE_W-1:0] epoch;
    } cap_s;

    cap_s cap_d, cap_q;
    logic sel_ok;
    logic slot_hit;

    always_comb begin
        sel_ok   = (chan_sel != '0) && (CMP_W'(chan_sel) <= CMP_W'(NUM_CH));
        slot_hit = in_frame && sel_ok
                   && (CMP_W'(word_idx) == CMP_W'(chan_sel) + CMP_W'(2));
        cap_d     = cap_q;
        cap_d.stb = 1'b0;
        if (hi_take) cap_d.hi = word_in[BYTE_W-1:0];
        if (lo_take) cap_d.epoch = {cap_q.hi, word_in};
        if (slot_hit) begin
            cap_d.sample = word_in;
            cap_d.stb    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else cap_q <= cap_d;
    end

    assign sample_q   = cap_q.sample;
    assign sample_stb = cap_q.stb;
    assign epoch_cnt  = cap_q.epoch;
endmodule

// File: rtl/chan_sample_extractor.sv
module chan_sample_extractor
    import cse_pkg::*;
#(
    parameter int NUM_CH = 320,
    parameter logic [7:0] SYNC_A = 8'h0A,
    parameter logic [7:0] SYNC_B = 8'h0B,
    parameter logic [7:0] SYNC_C = 8'h0C,
    localparam int FRAME_LEN = NUM_CH + HDR_WORDS,
    localparam int IDX_W = $clog2(FRAME_LEN),
    localparam int SEL_W = $clog2(NUM_CH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_vld,
    input  logic [15:0]      word_in,
    input  logic [SEL_W-1:0] chan_sel,
    output logic [15:0]      sample_q,
    output logic             sample_stb,
    output logic             locked,
    output logic [23:0]      epoch_cnt
);
    logic             lead_hit, tail_hit;
    logic             in_frame, hi_take, lo_take;
    logic [IDX_W-1:0] word_idx;

    cse_sync_cmp #(
        .SYNC_A(SYNC_A), .SYNC_B(SYNC_B), .SYNC_C(SYNC_C)
    ) u_cmp (
        .word_in (word_in),
        .lead_hit(lead_hit),
        .tail_hit(tail_hit)
    );

    cse_frame_trk #(.NUM_CH(NUM_CH)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_vld(word_vld),
        .lead_hit(lead_hit),
        .tail_hit(tail_hit),
        .locked  (locked),
        .in_frame(in_frame),
        .word_idx(word_idx),
        .hi_take (hi_take),
        .lo_take (lo_take)
    );

    cse_capture #(.NUM_CH(NUM_CH)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_in   (word_in),
        .chan_sel  (chan_sel),
        .in_frame  (in_frame),
        .word_idx  (word_idx),
        .hi_take   (hi_take),
        .lo_take   (lo_take),
        .sample_q  (sample_q),
        .sample_stb(sample_stb),
        .epoch_cnt (epoch_cnt)
    );
endmodule

// File: rtl/cse_checker.sv
module cse_checker #(
    parameter int NUM_CH = 320,
    parameter logic [7:0] SYNC_C = 8'h0C,
    localparam int SEL_W = $clog2(NUM_CH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_vld,
    input logic [15:0]      word_in,
    input logic [SEL_W-1:0] chan_sel,
    input logic [15:0]      sample_q,
    input logic             sample_stb,
    input logic             locked,
    input logic [23:0]      epoch_cnt
);
    p_lock_needs_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(word_vld) && $past(word_in[15:8]) == SYNC_C));

    p_stb_from_locked_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> ($past(locked) && $past(word_vld)));

    p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    p_sel_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> ($past(chan_sel) != '0 && $past(chan_sel) <= SEL_W'(NUM_CH)));

    p_epoch_on_locked_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(epoch_cnt) |-> ($past(locked) && $past(word_vld)));

    p_unlock_on_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(word_vld));

    p_idle_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!word_vld) |-> (!sample_stb && $stable(locked) && $stable(epoch_cnt)));

    p_sample_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |-> $stable(sample_q));
endmodule

bind chan_sample_extractor cse_checker #(.NUM_CH(NUM_CH), .SYNC_C(SYNC_C)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_vld  (word_vld),
    .word_in   (word_in),
    .chan_sel  (chan_sel),
    .sample_q  (sample_q),
    .sample_stb(sample_stb),
    .locked    (locked),
    .epoch_cnt (epoch_cnt)
);

// File: tb/chan_sample_extractor_tb.sv
module chan_sample_extractor_tb;
    localparam int NCH = 320;
    localparam int FLEN = NCH + 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_vld = 1'b0;
    logic [15:0] word_in = '0;
    logic [8:0]  chan_sel = '0;
    logic [15:0] sample_q;
    logic        sample_stb;
    logic        locked;
    logic [23:0] epoch_cnt;

    int checks = 0;
    int errors = 0;
    int frame_no = 0;
    logic [15:0] exp_sample = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    chan_sample_extractor #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_in),
        .chan_sel(chan_sel), .sample_q(sample_q), .sample_stb(sample_stb),
        .locked(locked), .epoch_cnt(epoch_cnt)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle, then settle just after the capturing edge
    task automatic put(input logic [15:0] w, input logic v);
        @(negedge clk);
        word_in  = w;
        word_vld = v;
        @(posedge clk);
        #1;
    endtask

    task automatic send_frame(input logic [23:0] ep, input logic [8:0] sel,
                              input bit gap, input bit from_hunt);
        logic [15:0] w;
        bit exp_stb;
        bool_sel: begin end
        chan_sel = sel;
        frame_no++;
        for (int i = 0; i < FLEN; i++) begin
            if (i == 0) w = 16'h0A0B;
            else if (i == 1) w = {8'h0C, ep[23:16]};
            else if (i == 2) w = ep[15:0];
            else w = {1'b1, 6'(frame_no), 9'(i)};
            if (gap && (i % 5 == 2)) begin
                for (int g = 0; g < 2; g++) begin
                    put(16'h0A0B, 1'b0);
                    check(!sample_stb, "R8 idle strobe", 32'(sample_stb), 0);
                    check(sample_q == exp_sample, "R8 idle sample", 32'(sample_q), 32'(exp_sample));
                end
            end
            put(w, 1'b1);
            exp_stb = (sel >= 1) && (sel <= NCH) && (i == int'(sel) + 2);
            if (sel >= 1 && sel <= NCH)
                check(sample_stb == exp_stb, "R4 strobe", 32'(sample_stb), 32'(exp_stb));
            else
                check(!sample_stb, "R5 strobe", 32'(sample_stb), 0);
            if (exp_stb) exp_sample = w;
            check(sample_q == exp_sample, "R9 sample", 32'(sample_q), 32'(exp_sample));
            if (i == 0 && from_hunt) check(!locked, "R2 early", 32'(locked), 0);
            if (i == 1) check(locked, "R2 lock", 32'(locked), 1);
            if (i == 2) check(epoch_cnt == ep, "R6 epoch", 32'(epoch_cnt), 32'(ep));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!locked && !sample_stb, "R1 flags", {30'd0, locked, sample_stb}, 0);
        check(sample_q == 0 && epoch_cnt == 0, "R1 data", {epoch_cnt, 8'd0} | 32'(sample_q), 0);
        rst_n = 1'b1;

        // R2: arbitrary data never locks
        for (int k = 0; k < 20; k++) begin
            put((k % 2 == 0) ? 16'h0C0C : (16'h8000 | 16'(k)), 1'b1);
            check(!locked, "R2 noise", 32'(locked), 0);
        end

        // R3: half pattern, then repeated lead words
        put(16'h0A0B, 1'b1);
        put(16'h0B0C, 1'b1);
        check(!locked, "R3 wrong tail", 32'(locked), 0);
        put(16'h0A0B, 1'b1);
        put(16'h0A0B, 1'b1);
        check(!locked, "R3 repeat lead", 32'(locked), 0);
        send_frame(24'hFFFFFF, 9'd1, 1'b0, 1'b1);

        // R4 / R5 / R6: sweep every channel, then out-of-range values
        for (int s = 2; s <= NCH; s++)
            send_frame({8'(s), 16'(s * 7)}, 9'(s), 1'b0, 1'b0);
        send_frame(24'h0A0B0C, 9'd0, 1'b0, 1'b0);
        send_frame(24'h000001, 9'd321, 1'b0, 1'b0);
        send_frame(24'h800000, 9'd511, 1'b0, 1'b0);

        // R8: idle cycles with sync-like data inside a locked frame
        send_frame(24'h123456, 9'd17, 1'b1, 1'b0);
        check(locked, "R8 lock kept", 32'(locked), 1);

        // R7: corrupt lead word at the frame boundary
        put(16'h1234, 1'b1);
        check(!locked, "R7 lead miss", 32'(locked), 0);
        check(sample_q == exp_sample, "R9 after loss", 32'(sample_q), 32'(exp_sample));
        send_frame(24'h00ABCD, 9'd320, 1'b0, 1'b1);

        // R7: corrupt tail byte at the frame boundary
        put(16'h0A0B, 1'b1);
        check(locked, "R7 lead ok", 32'(locked), 1);
        put(16'h0D55, 1'b1);
        check(!locked, "R7 tail miss", 32'(locked), 0);
        check(!sample_stb, "R7 no strobe", 32'(sample_stb), 0);
        send_frame(24'h7F0001, 9'd3, 1'b0, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule